// File: doc/BRIEF.md
# Display Serial Command/Data Transmitter

This block moves command and data bytes from a host to a display controller over a three- or four-wire serial link. The host offers one byte at a time with a valid/ready handshake. A side flag marks the byte as data (1) or as a command (0). The block turns each accepted byte into one framed word on the bus. It drives the chip select, the serial clock, the serial data line, a separate data/command line and an active-low panel reset.

A static format input picks how the data/command flag reaches the panel. It can travel as a leading ninth bit, as bit 8 of a zero-padded 16-bit word, or on the separate data/command line next to a plain 8-bit word. The serial clock is divided down from the system clock by a programmable half-period count. A software reset request drives the panel reset low for a programmable number of system clocks, and the block refuses bytes for that whole time.

Top module: `dbi_serial_tx`

## Requirements
- R1: With `fmt_i` = 2'b00, each word is 9 bits. The flag bit comes first, then the byte from bit 7 down to bit 0, so a command word starts with a 0 bit.
- R2: With `fmt_i` = 2'b01, each word is 16 bits: seven 0 bits, then the flag, then the byte from bit 7 down to bit 0.
- R3: With `fmt_i[1]` = 1, each word is the 8 byte bits, MSB first. `dcx_o` carries the flag (1 = data, 0 = command) from the cycle chip select falls until it rises. In the other two formats `dcx_o` stays 0 throughout every word.
- R4: The serial clock idles low and is high only while chip select is low. The data line changes only while the clock is low, so it is stable across every rising edge.
- R5: Let H be `half_div_i`, with 0 treated as 1. Every high and low level of the serial clock lasts exactly H system clocks. Chip select falls H clocks before the first rising edge and rises H clocks after the last falling edge.
- R6: Between two words, chip select stays high for at least 2·H system clocks.
- R7: `rdy_o` is high only when no word is in progress and the panel reset is released. A byte is taken on a clock edge where `vld_i` and `rdy_o` are both high. Each byte taken produces exactly one word.
- R8: If `sw_rst_i` is high at a clock edge, `panel_rst_n_o` is low for exactly `rst_len_i` system clocks after that edge. A length of 0 gives no pulse. While the reset is low, `rdy_o` is low and a valid byte is ignored: no word appears on the bus.
- R9: After `rst_n` is released, chip select is high, the serial clock and data line are low, `dcx_o` is low, `panel_rst_n_o` is high and `rdy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| fmt_i | input | 2 | Framing format, static while a word is in progress |
| half_div_i | input | DIV_W | Serial clock half-period in system clocks (0 acts as 1) |
| rst_len_i | input | RST_W | Panel reset pulse length in system clocks |
| sw_rst_i | input | 1 | Request for a panel reset pulse |
| vld_i | input | 1 | Host byte valid |
| rdy_o | output | 1 | Block can take a byte |
| byte_i | input | 8 | Payload byte |
| is_data_i | input | 1 | 1 = data byte, 0 = command byte |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data to the panel |
| dcx_o | output | 1 | Separate data/command line |
| panel_rst_n_o | output | 1 | Active-low panel reset |

## Verification
The bench builds the block with DIV_W = 2 and RST_W = 4. With these widths every divider setting, including the 0 case, and every reset length from 0 to 15 can be swept in full. At a half-period of 1, each of the three formats sends all 256 byte values with both flag values, back to back. The other half-periods use a strided subset of bytes, so level lengths, the select-to-clock setup and hold, and the inter-word gap are measured at every divider value.

// File: rtl/dbi_tx_pkg.sv
package dbi_tx_pkg;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned LEN_W  = $clog2(WORD_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_TAIL,
    ST_GAP
  } tx_state_e;

  // Left-aligned word: the bit at WORD_W-1 leaves first.
  function automatic logic [WORD_W-1:0] frame_word(logic [1:0] fmt, logic flag,
                                                   logic [7:0] payload);
    if (fmt[1])      return {payload, 8'h00};
    else if (fmt[0]) return {7'b0000000, flag, payload};
    else             return {flag, payload, 7'b0000000};
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(logic [1:0] fmt);
    if (fmt[1])      return LEN_W'(8);
    else if (fmt[0]) return LEN_W'(16);
    else             return LEN_W'(9);
  endfunction

endpackage

// File: rtl/dbi_tx_tick.sv
module dbi_tx_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] lim;
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    lim    = (half_i == '0) ? DIV_W'(1) : half_i;
    tick_o = run_i && (cnt_q == lim - DIV_W'(1));
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dbi_tx_rstgen.sv
module dbi_tx_rstgen #(
  parameter int unsigned RST_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [RST_W-1:0] len_i,
  output logic             rstn_o
);
  logic [RST_W-1:0] cnt_q, cnt_d;
  logic             rstn_q;

  always_comb begin
    if (start_i)            cnt_d = len_i;
    else if (cnt_q != '0)   cnt_d = cnt_q - RST_W'(1);
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rstn_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      rstn_q <= (cnt_d == '0);
    end
  end

  assign rstn_o = rstn_q;
endmodule

// File: rtl/dbi_tx_framer.sv
module dbi_tx_framer
  import dbi_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       hold_i,
  input  logic [1:0] fmt_i,
  input  logic       vld_i,
  input  logic [7:0] byte_i,
  input  logic       is_data_i,
  output logic       rdy_o,
  output logic       run_o,
  output logic       cs_n_o,
  output logic       sclk_o,
  output logic       sdo_o,
  output logic       dcx_o
);
  tx_state_e          st_q, st_d;
  logic [WORD_W-1:0]  sh_q, sh_d;
  logic [LEN_W-1:0]   left_q, left_d;
  logic               sclk_q, sclk_d;
  logic               csn_q, csn_d;
  logic               dc_q, dc_d;
  logic               line_q, line_d;
  logic               gap_q, gap_d;
  logic               take;

  assign rdy_o = (st_q == ST_IDLE) && !hold_i;
  assign take  = vld_i && rdy_o;

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    left_d = left_q;
    sclk_d = sclk_q;
    csn_d  = csn_q;
    dc_d   = dc_q;
    line_d = line_q;
    gap_d  = gap_q;
    unique case (st_q)
      ST_IDLE: if (take) begin
        sh_d   = frame_word(fmt_i, is_data_i, byte_i);
        left_d = frame_len(fmt_i);
        dc_d   = is_data_i;
        line_d = fmt_i[1];
        csn_d  = 1'b0;
        st_d   = ST_LOW;
      end
      ST_LOW: if (tick_i) begin
        sclk_d = 1'b1;
        st_d   = ST_HIGH;
      end
      ST_HIGH: if (tick_i) begin
        sclk_d = 1'b0;
        sh_d   = {sh_q[WORD_W-2:0], 1'b0};
        left_d = left_q - LEN_W'(1);
        st_d   = (left_q == LEN_W'(1)) ? ST_TAIL : ST_LOW;
      end
      ST_TAIL: if (tick_i) begin
        csn_d = 1'b1;
        gap_d = 1'b0;
        st_d  = ST_GAP;
      end
      ST_GAP: if (tick_i) begin
        gap_d = 1'b1;
        if (gap_q) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      left_q <= '0;
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
      dc_q   <= 1'b0;
      line_q <= 1'b0;
      gap_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      left_q <= left_d;
      sclk_q <= sclk_d;
      csn_q  <= csn_d;
      dc_q   <= dc_d;
      line_q <= line_d;
      gap_q  <= gap_d;
    end
  end

  assign run_o  = (st_q != ST_IDLE);
  assign cs_n_o = csn_q;
  assign sclk_o = sclk_q;
  assign sdo_o  = sh_q[WORD_W-1];
  assign dcx_o  = dc_q && line_q;
endmodule

// File: rtl/dbi_serial_tx.sv
module dbi_serial_tx #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned RST_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       fmt_i,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic [RST_W-1:0] rst_len_i,
  input  logic             sw_rst_i,
  input  logic             vld_i,
  output logic             rdy_o,
  input  logic [7:0]       byte_i,
  input  logic             is_data_i,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             sdo_o,
  output logic             dcx_o,
  output logic             panel_rst_n_o
);
  logic tick, run, prst_n;

  dbi_tx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .half_i (half_div_i),
    .tick_o (tick)
  );

  dbi_tx_rstgen #(.RST_W(RST_W)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (sw_rst_i),
    .len_i   (rst_len_i),
    .rstn_o  (prst_n)
  );

  dbi_tx_framer u_frm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .hold_i    (!prst_n),
    .fmt_i     (fmt_i),
    .vld_i     (vld_i),
    .byte_i    (byte_i),
    .is_data_i (is_data_i),
    .rdy_o     (rdy_o),
    .run_o     (run),
    .cs_n_o    (cs_n_o),
    .sclk_o    (sclk_o),
    .sdo_o     (sdo_o),
    .dcx_o     (dcx_o)
  );

  assign panel_rst_n_o = prst_n;
endmodule

// File: rtl/dbi_serial_tx_chk.sv
module dbi_serial_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic sw_rst_i,
  input logic vld_i,
  input logic rdy_o,
  input logic cs_n_o,
  input logic sclk_o,
  input logic sdo_o,
  input logic dcx_o,
  input logic panel_rst_n_o
);
  // R4
  sclk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> !cs_n_o);

  // R4
  sdo_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));

  // R3
  dcx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && $past(!cs_n_o)) |-> $stable(dcx_o));

  // R7
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> !rdy_o);

  // R7
  take_starts_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && rdy_o) |=> !cs_n_o);

  // R8
  rst_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !panel_rst_n_o |-> !rdy_o);

  // R8
  rst_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(panel_rst_n_o) |-> $past(sw_rst_i));
endmodule

bind dbi_serial_tx dbi_serial_tx_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sw_rst_i      (sw_rst_i),
  .vld_i         (vld_i),
  .rdy_o         (rdy_o),
  .cs_n_o        (cs_n_o),
  .sclk_o        (sclk_o),
  .sdo_o         (sdo_o),
  .dcx_o         (dcx_o),
  .panel_rst_n_o (panel_rst_n_o)
);

// File: tb/sim_dbi_serial_tx.sv
`timescale 1ns/1ps
module sim_dbi_serial_tx;
  localparam int DW = 2;
  localparam int RW = 4;
  localparam int WATCHDOG = 190000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    fmt = 2'b00;
  logic [DW-1:0] half = '0;
  logic [RW-1:0] rlen = '0;
  logic          swr = 1'b0;
  logic          vld = 1'b0;
  logic          rdy;
  logic [7:0]    byt = 8'h00;
  logic          isd = 1'b0;
  logic          cs_n, sclk, sdo, dcx, prst_n;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dbi_serial_tx #(.DIV_W(DW), .RST_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .half_div_i(half),
    .rst_len_i(rlen), .sw_rst_i(swr), .vld_i(vld), .rdy_o(rdy),
    .byte_i(byt), .is_data_i(isd), .cs_n_o(cs_n), .sclk_o(sclk),
    .sdo_o(sdo), .dcx_o(dcx), .panel_rst_n_o(prst_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  // Bus monitor
  logic [8:0]  exp_q[$];
  bit          mon_en = 0;
  bit          p_cs, p_sclk, p_sdo, dc0, terr, derr;
  int          ph, nb, gap, words;
  logic [15:0] rx;

  function automatic int hexp();
    return (half == '0) ? 1 : int'(half);
  endfunction

  always @(negedge clk) begin
    if (mon_en) begin
      ph++;
      if (p_cs && !cs_n) begin
        // R6
        if (words > 0) chk(gap >= 2 * hexp(), "R6 gap", gap, 2 * hexp());
        ph = 0; nb = 0; rx = '0; terr = 0; derr = 0; dc0 = dcx;
      end
      if (!p_sclk && sclk) begin
        if (ph != hexp()) terr = 1;
        ph = 0;
        rx = {rx[14:0], sdo};
        nb++;
      end
      if (p_sclk && !sclk) begin
        if (ph != hexp()) terr = 1;
        ph = 0;
      end
      if (p_sclk && sclk && (sdo != p_sdo)) terr = 1;
      if (sclk && cs_n) terr = 1;
      if (!cs_n && !p_cs && (dcx != dc0)) derr = 1;
      if (!p_cs && cs_n) begin
        if (ph != hexp()) terr = 1;
        words++;
        if (exp_q.size() == 0) begin
          chk(0, "R7 word without byte", words, 0);
        end else begin
          logic [8:0]  e;
          logic [15:0] ew;
          int          el;
          bit          edc;
          e = exp_q.pop_front();
          if (fmt[1]) begin
            ew = {8'h00, e[7:0]}; el = 8; edc = e[8];
          end else if (fmt[0]) begin
            ew = {7'b0, e[8], e[7:0]}; el = 16; edc = 0;
          end else begin
            ew = {7'b0, e[8], e[7:0]}; el = 9; edc = 0;
          end
          if (fmt[1])
            chk(nb == el && rx == ew, "R3 word bits", int'({nb[7:0], rx}), int'({el[7:0], ew}));
          else if (fmt[0])
            chk(nb == el && rx == ew, "R2 word bits", int'({nb[7:0], rx}), int'({el[7:0], ew}));
          else
            chk(nb == el && rx == ew, "R1 word bits", int'({nb[7:0], rx}), int'({el[7:0], ew}));
          // R3 data/command line
          chk(dc0 == edc && !derr, "R3 dcx", int'({derr, dc0}), int'(edc));
        end
        // R4 and R5 edge placement and level lengths
        chk(!terr, "R5 R4 timing", int'(terr), 0);
      end
      gap = cs_n ? gap + 1 : 0;
      p_cs = cs_n; p_sclk = sclk; p_sdo = sdo;
    end
  end

  task automatic send(input logic [7:0] b, input bit f);
    @(negedge clk);
    vld = 1'b1; byt = b; isd = f;
    while (!rdy) @(negedge clk);
    @(posedge clk);
    exp_q.push_back({f, b});
  endtask

  task automatic drain();
    @(negedge clk);
    vld = 1'b0;
    repeat (2) @(negedge clk);
    while (!rdy || !cs_n) @(negedge clk);
    repeat (10) @(negedge clk);
    // R7 one word per accepted byte
    chk(exp_q.size() == 0, "R7 pending bytes", exp_q.size(), 0);
  endtask

  task automatic run_cfg(input logic [1:0] m, input int h, input int step);
    @(negedge clk);
    fmt = m; half = DW'(h);
    for (int b = 0; b < 256; b += step)
      for (int f = 0; f < 2; f++)
        send(8'(b), f[0]);
    drain();
  endtask

  task automatic rst_pulse(input int len);
    int lowc;
    int w0;
    bit bad;
    w0 = words;
    bad = 0;
    lowc = 0;
    @(negedge clk);
    rlen = RW'(len); swr = 1'b1;
    @(negedge clk);
    swr = 1'b0;
    vld = 1'b1; byt = 8'hA5; isd = 1'b1;
    while (!prst_n && lowc < 40) begin
      lowc++;
      if (rdy || !cs_n) bad = 1;
      @(negedge clk);
    end
    vld = 1'b0;
    // R8 pulse length
    chk(lowc == len, "R8 reset length", lowc, len);
    chk(!bad, "R8 ready or bus active during reset", int'(bad), 0);
    repeat (12) @(negedge clk);
    chk(words == w0 && cs_n, "R8 byte ignored during reset", words - w0, 0);
    chk(prst_n && rdy, "R8 reset released", int'({prst_n, rdy}), 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(cs_n == 1'b1, "R9 cs_n", int'(cs_n), 1);
    chk(sclk == 1'b0 && sdo == 1'b0, "R9 sclk sdo", int'({sclk, sdo}), 0);
    chk(dcx == 1'b0, "R9 dcx", int'(dcx), 0);
    chk(prst_n == 1'b1 && rdy == 1'b1, "R9 prst rdy", int'({prst_n, rdy}), 3);
    p_cs = 1; p_sclk = 0; p_sdo = 0; ph = 0; gap = 0; words = 0;
    mon_en = 1;

    // full byte sweep at a half-period of 1 for every format
    run_cfg(2'b00, 1, 1);
    run_cfg(2'b01, 1, 1);
    run_cfg(2'b10, 1, 1);
    // every other divider setting, including 0
    for (int h = 0; h < 4; h++) begin
      if (h == 1) continue;
      run_cfg(2'b00, h, 17);
      run_cfg(2'b01, h, 17);
      run_cfg(2'b10, h, 17);
      run_cfg(2'b11, h, 17);
    end

    // every panel reset length
    for (int l = 0; l < 16; l++) rst_pulse(l);

    // traffic still works after the reset sweep
    run_cfg(2'b10, 2, 51);
    finish_run();
  end
endmodule